// File: doc/BRIEF.md
# Byte-Lane Parallel EEPROM Write Sequencer

This block sits on the host side of a 32-bit wide array made of four byte-wide parallel EEPROM devices. The devices share one address bus, one output-enable line and the data bus. Each device has its own active-low chip select and active-low write enable. A client hands the block one write at a time over a valid/ready handshake: an address, a 32-bit data word, a four-bit byte-lane mask and a flag that marks the last byte of a page. Because only the masked lanes are strobed, the same array serves as 32-, 16- or 8-bit wide memory.

Each write becomes a cycle driven by write enable. Chip select, address and data are set up first. Write enable then goes low for the minimum pulse width, and everything is held stable after it rises. Every timing minimum is given in nanoseconds and is converted to a whole number of clock cycles, always rounded up. After a byte that is not the last of its page, the block keeps the page open and accepts the next byte only while its write strobe can still fall within the page window. The page window is measured from the previous falling edge. When the last byte has been written, or when the window closes with no new byte, the block holds off all requests for the full programming time.

Top module: `eeprom_wr_seq`

## Requirements
- R1: While reset is held, every chip select and write enable is high, the data drive enable is low, programming and opDone are low, and reqReady is high.
- R2: memOeN is high at all times. memDoutEn is high whenever any chip select is low.
- R3: Lane i (i = 0..3) is bit i of reqMask and data bits 8i+7:8i. Only lanes whose mask bit is set see a low chip select or write enable. A lane's write enable is never low while its chip select is high.
- R4: Each write-enable low pulse lasts exactly WP = ceil(T_WP_NS*1000/CLK_PS) cycles.
- R5: Chip select, address and data are valid for one cycle before write enable falls. They stay unchanged while it is low and for exactly HC cycles after it rises, where HC = max(ceil DH, ceil WPH, ceil AH - WP, 1). After that, chip select returns high.
- R6: A request with an all-zero mask is accepted, produces no strobe, and raises opDone in the cycle after acceptance. It never starts programming.
- R7: After a byte that is not last, opDone pulses in the cycle after its hold phase, which is WP+HC+2 cycles after acceptance. A following byte of the same page falls no later than WIN = ceil(T_WIN_NS*1000/CLK_PS) cycles after the previous fall.
- R8: If no byte arrives, reqReady is low in the last window cycle and programming rises exactly WIN cycles after the previous fall. That programming wait ends without an opDone pulse.
- R9: After a last byte, programming stays high for exactly PROG = ceil(T_PROG_NS*1000/CLK_PS) cycles with reqReady low throughout. opDone pulses in the first cycle after.
- R10: A request offered while reqReady is low is neither lost nor strobed early. It is accepted and written once the block is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request can be accepted this cycle |
| reqAddr | input | ADDR_W | Device word address |
| reqData | input | 32 | Write data, four byte lanes |
| reqMask | input | 4 | Byte-lane enable, bit i selects lane i |
| reqLast | input | 1 | Last byte of the page; start programming after it |
| opDone | output | 1 | One-cycle completion pulse |
| programming | output | 1 | Programming wait in progress |
| memAddr | output | ADDR_W | Shared device address |
| memDout | output | 32 | Data to the devices |
| memDoutEn | output | 1 | Data bus drive enable |
| memOeN | output | 1 | Shared output enable, active low |
| memCsN | output | 4 | Per-lane chip select, active low |
| memWeN | output | 4 | Per-lane write enable, active low |

## Verification
The bench aims at pulse-width rounding by running at a clock period that does not divide the nanosecond minimums. A design that truncated instead of rounding up would produce strobes one cycle short. It walks 32-, 16- and 8-bit masks across a chained page, so a wrong lane map or a lane strobed outside its mask shows up as a chip select or data byte on the wrong lane. The page window is left to expire on purpose: an off-by-one window counter would start programming a cycle early or late, and a design that treated expiry like a last byte would emit a spurious opDone. Zero-mask requests and requests offered during programming catch designs that strobe an empty lane set or drop a waiting request.

// File: rtl/eeprom_wr_pkg.sv
package eeprom_wr_pkg;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic capture;   // load request fields into the datapath
    logic select;    // assert chip select on masked lanes
    logic weLow;     // assert write enable on masked lanes
    logic drive;     // drive the data bus
  } wr_strobe_t;

  // Convert a minimum time in ns to clock cycles, rounding up, at least one.
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned ps);
    longint unsigned c;
    c = (64'(ns) * 64'd1000 + 64'(ps) - 64'd1) / 64'(ps);
    if (c == 64'd0) c = 64'd1;
    return c[31:0];
  endfunction

  function automatic int unsigned maxU(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/eeprom_wr_ctrl.sv
module eeprom_wr_ctrl
  import eeprom_wr_pkg::*;
#(
  parameter int unsigned WP_CYC   = 10,
  parameter int unsigned HC_CYC   = 5,
  parameter int unsigned WIN_CYC  = 15000,
  parameter int unsigned PROG_CYC = 1000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqLast,
  input  logic       reqAny,
  output logic       reqReady,
  output logic       opDone,
  output logic       programming,
  output wr_strobe_t strobe
);

  localparam int unsigned CNT_MAX = maxU(maxU(WP_CYC, HC_CYC), PROG_CYC);
  localparam int unsigned CW      = $clog2(CNT_MAX + 1);
  localparam int unsigned WW      = $clog2(WIN_CYC + 1);
  localparam logic [CW-1:0] WP_LAST   = CW'(WP_CYC - 1);
  localparam logic [CW-1:0] HC_LAST   = CW'(HC_CYC - 1);
  localparam logic [CW-1:0] PROG_LAST = CW'(PROG_CYC - 1);
  // Acceptance at count w puts the next fall at w+2.
  localparam logic [WW-1:0] WIN_OPEN_MAX = WW'(WIN_CYC - 2);
  localparam logic [WW-1:0] WIN_SAT      = WW'(WIN_CYC - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_STROBE, S_HOLD, S_GAP, S_PROG
  } seq_state_t;

  seq_state_t    state;
  logic [CW-1:0] cnt;
  logic [WW-1:0] winCnt;
  logic          lastQ;
  logic          progLast;
  logic          doneQ;
  logic          windowOpen;
  logic          accept;

  assign windowOpen  = (winCnt <= WIN_OPEN_MAX);
  assign reqReady    = (state == S_IDLE) || ((state == S_GAP) && windowOpen);
  assign accept      = reqValid && reqReady;
  assign opDone      = doneQ;
  assign programming = (state == S_PROG);

  always_comb begin
    strobe.capture = accept && reqAny;
    strobe.select  = (state == S_SETUP) || (state == S_STROBE) || (state == S_HOLD);
    strobe.weLow   = (state == S_STROBE);
    strobe.drive   = strobe.select;
  end

  // Window age since the last write-enable fall, saturating.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (state == S_SETUP) begin
      winCnt <= '0;
    end else if (winCnt != WIN_SAT) begin
      winCnt <= winCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      cnt      <= '0;
      lastQ    <= 1'b0;
      progLast <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (state)
        S_IDLE, S_GAP: begin
          if (accept) begin
            if (reqAny) begin
              state <= S_SETUP;
              lastQ <= reqLast;
            end else begin
              doneQ <= 1'b1;
            end
          end else if ((state == S_GAP) && (winCnt >= WIN_SAT)) begin
            state    <= S_PROG;
            cnt      <= '0;
            progLast <= 1'b0;
          end
        end
        S_SETUP: begin
          state <= S_STROBE;
          cnt   <= '0;
        end
        S_STROBE: begin
          if (cnt == WP_LAST) begin
            state <= S_HOLD;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_HOLD: begin
          if (cnt == HC_LAST) begin
            cnt <= '0;
            if (lastQ) begin
              state    <= S_PROG;
              progLast <= 1'b1;
            end else begin
              state <= S_GAP;
              doneQ <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PROG: begin
          if (cnt == PROG_LAST) begin
            state <= S_IDLE;
            cnt   <= '0;
            doneQ <= progLast;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/eeprom_wr_dpath.sv
module eeprom_wr_dpath
  import eeprom_wr_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  wr_strobe_t              strobe,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [LANES*LANE_W-1:0] reqData,
  input  logic [LANES-1:0]        reqMask,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [LANES*LANE_W-1:0] memDout,
  output logic                    memDoutEn,
  output logic                    memOeN,
  output logic [LANES-1:0]        memCsN,
  output logic [LANES-1:0]        memWeN
);

  logic [ADDR_W-1:0]       addrQ;
  logic [LANES*LANE_W-1:0] dataQ;
  logic [LANES-1:0]        maskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      maskQ <= '0;
    end else if (strobe.capture) begin
      addrQ <= reqAddr;
      dataQ <= reqData;
      maskQ <= reqMask;
    end
  end

  assign memAddr   = addrQ;
  assign memDout   = dataQ;
  assign memDoutEn = strobe.drive;
  assign memOeN    = 1'b1;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign memCsN[g] = ~(strobe.select && maskQ[g]);
    assign memWeN[g] = ~(strobe.weLow  && maskQ[g]);
  end

endmodule

// File: rtl/eeprom_wr_seq.sv
module eeprom_wr_seq
  import eeprom_wr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 17,
  parameter int unsigned CLK_PS    = 10000,
  parameter int unsigned T_WP_NS   = 100,
  parameter int unsigned T_WPH_NS  = 50,
  parameter int unsigned T_DH_NS   = 10,
  parameter int unsigned T_AH_NS   = 100,
  parameter int unsigned T_WIN_NS  = 150000,
  parameter int unsigned T_PROG_NS = 10000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqData,
  input  logic [3:0]        reqMask,
  input  logic              reqLast,
  output logic              opDone,
  output logic              programming,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memDout,
  output logic              memDoutEn,
  output logic              memOeN,
  output logic [3:0]        memCsN,
  output logic [3:0]        memWeN
);

  localparam int unsigned LANES    = 4;
  localparam int unsigned LANE_W   = 8;
  localparam int unsigned WP_CYC   = ns2cyc(T_WP_NS, CLK_PS);
  localparam int unsigned AH_CYC   = ns2cyc(T_AH_NS, CLK_PS);
  localparam int unsigned AH_REST  = (AH_CYC > WP_CYC) ? (AH_CYC - WP_CYC) : 1;
  localparam int unsigned HC_CYC   = maxU(maxU(ns2cyc(T_DH_NS, CLK_PS), ns2cyc(T_WPH_NS, CLK_PS)), AH_REST);
  localparam int unsigned WIN_CYC  = ns2cyc(T_WIN_NS, CLK_PS);
  localparam int unsigned PROG_CYC = ns2cyc(T_PROG_NS, CLK_PS);

  wr_strobe_t strobe;

  eeprom_wr_ctrl #(
    .WP_CYC  (WP_CYC),
    .HC_CYC  (HC_CYC),
    .WIN_CYC (WIN_CYC),
    .PROG_CYC(PROG_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqLast    (reqLast),
    .reqAny     (|reqMask),
    .reqReady   (reqReady),
    .opDone     (opDone),
    .programming(programming),
    .strobe     (strobe)
  );

  eeprom_wr_dpath #(
    .ADDR_W(ADDR_W),
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqData  (reqData),
    .reqMask  (reqMask),
    .memAddr  (memAddr),
    .memDout  (memDout),
    .memDoutEn(memDoutEn),
    .memOeN   (memOeN),
    .memCsN   (memCsN),
    .memWeN   (memWeN)
  );

endmodule

// File: rtl/eeprom_wr_seq_chk.sv
module eeprom_wr_seq_chk #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned WP_CYC = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [3:0]        reqMask,
  input logic              opDone,
  input logic              programming,
  input logic [ADDR_W-1:0] memAddr,
  input logic [31:0]       memDout,
  input logic              memDoutEn,
  input logic              memOeN,
  input logic [3:0]        memCsN,
  input logic [3:0]        memWeN
);

  localparam int unsigned LW = $clog2(WP_CYC + 2);

  logic          weAllHigh;
  logic [LW-1:0] lowCnt;

  assign weAllHigh = (memWeN == 4'hF);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
    end else if (weAllHigh) begin
      lowCnt <= '0;
    end else if (lowCnt != LW'(WP_CYC + 1)) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  // R2
  p_oe_drive_r2: assert property (@(posedge clk) disable iff (!rstN)
    memOeN && ((memCsN != 4'hF) -> memDoutEn));

  // R3
  p_we_inside_cs_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((~memWeN) & memCsN) == 4'h0);

  // R4: pulse never shorter than the minimum
  p_min_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    (weAllHigh && !$past(weAllHigh)) |-> (lowCnt >= LW'(WP_CYC)));

  // R5
  p_bus_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!weAllHigh && $past(!weAllHigh)) |-> ($stable(memAddr) && $stable(memDout) && $stable(memCsN)));

  // R6
  p_zero_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && (reqMask == 4'h0)) |=> (opDone && weAllHigh));

  // R9
  p_ready_low_prog_r9: assert property (@(posedge clk) disable iff (!rstN)
    programming |-> !reqReady);

endmodule

bind eeprom_wr_seq eeprom_wr_seq_chk #(
  .ADDR_W(ADDR_W),
  .WP_CYC(WP_CYC)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .reqMask    (reqMask),
  .opDone     (opDone),
  .programming(programming),
  .memAddr    (memAddr),
  .memDout    (memDout),
  .memDoutEn  (memDoutEn),
  .memOeN     (memOeN),
  .memCsN     (memCsN),
  .memWeN     (memWeN)
);

// File: tb/eeprom_wr_seq_tb.sv
module eeprom_wr_seq_tb;

  localparam int CLK_PERIOD = 8;
  localparam int CLK_PS     = CLK_PERIOD * 1000;
  localparam int ADDR_W     = 17;
  localparam int T_WP = 100, T_WPH = 50, T_DH = 10, T_AH = 100;
  localparam int T_WIN = 2000, T_PROG = 4000;

  function automatic int toCyc(int ns);
    int c;
    c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int WP   = toCyc(T_WP);
  localparam int WPH  = toCyc(T_WPH);
  localparam int DH   = toCyc(T_DH);
  localparam int AHR  = (toCyc(T_AH) > WP) ? toCyc(T_AH) - WP : 1;
  localparam int HC   = (DH > WPH) ? ((DH > AHR) ? DH : AHR) : ((WPH > AHR) ? WPH : AHR);
  localparam int WIN  = toCyc(T_WIN);
  localparam int PROG = toCyc(T_PROG);

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [31:0]       data;
    logic [3:0]        mask;
    bit                chained;
  } exp_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [31:0]       reqData = '0;
  logic [3:0]        reqMask = '0;
  logic              reqLast = 1'b0;
  logic              opDone, programming, memDoutEn, memOeN;
  logic [ADDR_W-1:0] memAddr;
  logic [31:0]       memDout;
  logic [3:0]        memCsN, memWeN;

  int   cyc = 0;
  int   nChecks = 0;
  int   nErrors = 0;
  bit   ended = 0;
  exp_t expQ[$];

  eeprom_wr_seq #(
    .ADDR_W(ADDR_W), .CLK_PS(CLK_PS), .T_WP_NS(T_WP), .T_WPH_NS(T_WPH),
    .T_DH_NS(T_DH), .T_AH_NS(T_AH), .T_WIN_NS(T_WIN), .T_PROG_NS(T_PROG)
  ) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqData(reqData), .reqMask(reqMask), .reqLast(reqLast),
    .opDone(opDone), .programming(programming), .memAddr(memAddr),
    .memDout(memDout), .memDoutEn(memDoutEn), .memOeN(memOeN),
    .memCsN(memCsN), .memWeN(memWeN)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] laneBits(input logic [3:0] m);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[i*8 +: 8] = {8{m[i]}};
    return r;
  endfunction

  // Monitor: pops one expected item per write-enable pulse.
  bit          prevWeLow = 0, inHold = 0;
  logic [3:0]  prevCsN = 4'hF;
  logic        prevEn = 1'b0;
  logic [ADDR_W-1:0] prevAddr = '0;
  int          width = 0, holdCnt = 0, lastFall = 0;
  exp_t        cur;

  always @(negedge clk) begin
    bit weLow;
    weLow = (memWeN != 4'hF);
    if (rstN) begin
      check(memOeN == 1'b1, "R2 oe high", memOeN, 1);
      if (weLow && !prevWeLow) begin
        if (expQ.size() == 0) begin
          check(0, "R3 unexpected strobe", memWeN, 4'hF);
        end else begin
          cur = expQ.pop_front();
          check(memWeN == ~cur.mask && memCsN == ~cur.mask, "R3 lane strobes", {memCsN, memWeN}, {~cur.mask, ~cur.mask});
          check(prevCsN == ~cur.mask && prevEn && prevAddr == cur.addr, "R5 setup before fall", prevAddr, cur.addr);
          if (cur.chained) begin
            check((cyc - lastFall) <= WIN && (cyc - lastFall) >= WP + WPH, "R7 page spacing", cyc - lastFall, WIN);
          end
        end
        lastFall = cyc;
        width = 0;
      end
      if (weLow) begin
        width++;
        check(memAddr == cur.addr && ((memDout ^ cur.data) & laneBits(cur.mask)) == 0,
              "R5 bus during pulse", memDout, cur.data);
      end
      if (!weLow && prevWeLow) begin
        check(width == WP, "R4 pulse width", width, WP);
        inHold = 1;
        holdCnt = 0;
      end
      if (inHold && !weLow) begin
        if (memCsN != 4'hF) begin
          holdCnt++;
          check(memCsN == ~cur.mask && memAddr == cur.addr && memDoutEn &&
                ((memDout ^ cur.data) & laneBits(cur.mask)) == 0, "R5 hold values", memAddr, cur.addr);
        end else begin
          check(holdCnt == HC, "R5 hold length", holdCnt, HC);
          inHold = 0;
        end
      end
    end
    prevWeLow = weLow;
    prevCsN   = memCsN;
    prevEn    = memDoutEn;
    prevAddr  = memAddr;
  end

  // Driver: offers one request and returns at the negedge after acceptance.
  task automatic sendReq(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                         input logic [3:0] m, input bit last, input bit chained);
    exp_t e;
    @(negedge clk);
    reqAddr = a; reqData = d; reqMask = m; reqLast = last; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    if (m != 4'h0) begin
      e.addr = a; e.data = d; e.mask = m; e.chained = chained;
      expQ.push_back(e);
    end
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDone(output int total, output int progCnt);
    total = 0;
    progCnt = 0;
    forever begin
      @(negedge clk);
      total++;
      if (programming) begin
        progCnt++;
        if (reqReady) check(0, "R9 ready during programming", 1, 0);
      end
      if (opDone || total > 20000) break;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 60000 && !ended) begin
        ended = 1;
        nErrors++;
        nChecks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 60000);
        $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
        $finish;
      end
    end
  end

  initial begin
    int tot, pc, riseCyc;
    bit prevReady;
    repeat (3) @(negedge clk);
    check(memCsN == 4'hF && memWeN == 4'hF && !memDoutEn && memOeN && !programming && !opDone && reqReady,
          "R1 reset state", {memCsN, memWeN}, 8'hFF);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // Full word, last byte of page
    sendReq(17'h00010, 32'hA5C3_1E77, 4'hF, 1, 0);
    waitDone(tot, pc);
    check(pc == PROG, "R9 programming length", pc, PROG);
    check(!programming && opDone, "R9 done after programming", programming, 0);

    // Chained page: 16-bit, 16-bit upper, 8-bit, 8-bit last
    sendReq(17'h00100, 32'h1234_5678, 4'b0011, 0, 0);
    waitDone(tot, pc);
    check(tot == WP + HC + 1 && pc == 0, "R7 opDone timing", tot, WP + HC + 1);
    repeat (30) @(negedge clk);
    sendReq(17'h00101, 32'h9ABC_DEF0, 4'b1100, 0, 1);
    waitDone(tot, pc);
    check(tot == WP + HC + 1, "R7 opDone timing chained", tot, WP + HC + 1);
    sendReq(17'h00102, 32'h00C7_0000, 4'b0100, 0, 1);
    waitDone(tot, pc);
    sendReq(17'h00103, 32'h3E00_0000, 4'b1000, 1, 1);
    waitDone(tot, pc);
    check(pc == PROG, "R9 programming after page", pc, PROG);

    // Zero mask, plain and flagged last
    sendReq(17'h00055, 32'hFFFF_FFFF, 4'h0, 0, 0);
    check(opDone && memWeN == 4'hF && memCsN == 4'hF, "R6 zero mask done", opDone, 1);
    sendReq(17'h00056, 32'hFFFF_FFFF, 4'h0, 1, 0);
    check(opDone, "R6 zero mask last done", opDone, 1);
    repeat (3) @(negedge clk);
    check(!programming && memCsN == 4'hF && reqReady, "R6 zero mask no programming", programming, 0);

    // Window expiry, with a request waiting during programming
    sendReq(17'h00200, 32'h0000_005A, 4'b0001, 0, 0);
    waitDone(tot, pc);
    prevReady = reqReady;
    while (!programming) begin
      prevReady = reqReady;
      @(negedge clk);
    end
    riseCyc = cyc;
    check(riseCyc - lastFall == WIN, "R8 window expiry", riseCyc - lastFall, WIN);
    check(!prevReady, "R8 ready closed before expiry", prevReady, 0);
    fork
      begin
        pc = 1;
        forever begin
          @(negedge clk);
          if (programming) pc++;
          else break;
        end
        check(pc == PROG, "R8 expiry programming length", pc, PROG);
        check(!opDone, "R8 no done after expiry", opDone, 0);
      end
      begin
        repeat (20) @(negedge clk);
        sendReq(17'h00300, 32'h00BE_EF00, 4'b0110, 1, 0);
      end
    join
    waitDone(tot, pc);
    check(pc == PROG, "R10 held request programmed", pc, PROG);
    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R10 all requests written", expQ.size(), 0);

    if (!ended) begin
      ended = 1;
      $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

endmodule